// File: doc/BRIEF.md
# Powerdown Wake-Up and Event-Latch Controller

This block sequences a processor core into and out of its low-power state. A powerdown request halts the core and, if clock stopping is selected, drops the core clock enable. While the core sleeps, the block keeps watching its free-running input clock: it times how long the reset pin stays low, and only a low pulse long enough for the current clock situation counts as a wake-up. A separate wake input gives an exit that does not need the reset pin.

Events that arrive while the core is asleep are captured rather than lost. Interrupt requests become sticky pending flags that the core acknowledges bit by bit. Serial-port autobuffer requests are deferred and replayed, one per cycle with receive ahead of transmit, after an exit that keeps the core context. A receive holding register keeps the last received word until the core reads it. Exits that reset the core context discard the pending flags and the deferred transfers, but never the received word.

Top module: `pd_wake_ctrl`

## Requirements
- R1: After reset the block is in the running state: halt_o=0, clk_en_o=1, core_rst_o=0, irq_pend_o=0, ab_go_o=0, rx_full_o=0.
- R2: A cycle with pd_req_i=1 while running sets halt_o=1 from the next cycle; clk_en_o is then 0 when clk_stop_i was 1 in the request cycle, else 1.
- R3: With the clock kept running in powerdown, core_rst_ni low for 5 consecutive cycles exits powerdown; 4 cycles does not.
- R4: With the clock stopped in powerdown, core_rst_ni low for 3000 consecutive cycles exits powerdown; 2999 cycles does not.
- R5: A reset pulse shorter than the threshold is ignored and the block stays halted; the count restarts from zero at the next low cycle.
- R6: Exit passes through a wake cycle (halt_o=1, clk_en_o=1), then a resume phase, then halt_o=0.
- R7: Each irq_i bit sets its irq_pend_o bit in any state; a bit stays set until the matching irq_ack_i bit is 1.
- R8: An exit by wake_i with ctx_keep_i=1 keeps irq_pend_o. An exit by the reset pin, or by wake_i with ctx_keep_i=0, clears irq_pend_o and raises core_rst_o for exactly the wake cycle.
- R9: ab_go_o is 0 while halted outside the resume phase; ab_req_i seen then is deferred. After a context-keeping exit, pending requests are issued one per cycle during resume, bit 0 (receive) before bit 1 (transmit); a resetting exit discards them.
- R10: rx_data_o loads rx_data_i when rx_valid_i=1 and sets rx_full_o; it holds its value across every kind of exit; rx_rd_i=1 clears rx_full_o.
- R11: In powerdown with the clock stopped and sclk_ext_i=0, rx_valid_i and ab_req_i are ignored.
- R12: While running, ab_go_o follows ab_req_i in the same cycle and core_rst_o follows the inverse of core_rst_ni.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running input clock |
| rst_ni | input | 1 | Block asynchronous reset, active low |
| pd_req_i | input | 1 | Powerdown request |
| clk_stop_i | input | 1 | Stop core clock during powerdown |
| wake_i | input | 1 | Non-reset powerdown exit request |
| ctx_keep_i | input | 1 | 1: wake exit keeps core context |
| core_rst_ni | input | 1 | Reset pin, active low |
| irq_i | input | N_IRQ | Interrupt requests |
| irq_ack_i | input | N_IRQ | Per-bit pending clear from core |
| ab_req_i | input | 2 | Autobuffer requests, bit 0 receive, bit 1 transmit |
| sclk_ext_i | input | 1 | Serial clock is supplied externally |
| rx_valid_i | input | 1 | Received word strobe |
| rx_data_i | input | DW | Received word |
| rx_rd_i | input | 1 | Core reads receive register |
| halt_o | output | 1 | Core halted |
| clk_en_o | output | 1 | Core clock enable |
| core_rst_o | output | 1 | Core reset |
| irq_pend_o | output | N_IRQ | Sticky pending interrupts |
| ab_go_o | output | 2 | Autobuffer transfer strobes |
| rx_data_o | output | DW | Receive holding register |
| rx_full_o | output | 1 | Receive register holds unread data |

## Verification
A table of reset pulses sweeps both clock situations with lengths one short of and equal to each threshold, plus a one-cycle glitch, which separates an off-by-one count and a swapped threshold. A split pulse (three low, one high, three low) distinguishes a restarting count from an accumulating one. Events injected while asleep are followed through each of the three exit kinds, telling kept state from discarded state and checking the receive-before-transmit replay order. A stopped clock with internal and then external serial clock shows whether serial traffic is gated exactly in that case.

// File: rtl/pd_wake_pkg.sv
package pd_wake_pkg;
  typedef enum logic [1:0] {
    S_RUN    = 2'd0,
    S_PDOWN  = 2'd1,
    S_WAKE   = 2'd2,
    S_RESUME = 2'd3
  } pd_state_e;
endpackage

// File: rtl/pd_rst_timer.sv
module pd_rst_timer #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          low_i,
  input  logic [CW-1:0] thr_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  // count consecutive low cycles; any high cycle restarts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || !low_i) cnt_q <= '0;
    else if (!hit_o)          cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = en_i && low_i && (cnt_q == thr_i - 1'b1);
endmodule

// File: rtl/pd_event_latch.sv
module pd_event_latch #(
  parameter int N_IRQ = 4,
  parameter int N_AB  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_ack_i,
  input  logic [N_AB-1:0]  ab_req_i,
  input  logic             ab_cap_i,
  input  logic             ab_pass_i,
  input  logic             drain_i,
  output logic [N_IRQ-1:0] irq_pend_o,
  output logic [N_AB-1:0]  ab_go_o,
  output logic             ab_left_o
);
  logic [N_IRQ-1:0] pend_q;
  logic [N_AB-1:0]  ab_q, ab_d, grant;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= '0;
    else if (clr_i) pend_q <= '0;
    else            pend_q <= (pend_q & ~irq_ack_i) | irq_i;
  end

  // lowest index wins: receive before transmit
  always_comb begin
    grant = '0;
    if (drain_i) begin
      for (int i = 0; i < N_AB; i++) begin
        if (ab_q[i] && grant == '0) grant[i] = 1'b1;
      end
    end
  end

  always_comb begin
    ab_d = (ab_q & ~grant) | (ab_cap_i ? ab_req_i : '0);
    if (clr_i) ab_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ab_q <= '0;
    else         ab_q <= ab_d;
  end

  assign irq_pend_o = pend_q;
  assign ab_go_o    = ab_pass_i ? ab_req_i : grant;
  assign ab_left_o  = |ab_d;
endmodule

// File: rtl/pd_rx_hold.sv
module pd_rx_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic          full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (load_i) begin
      data_o <= data_i;
      full_o <= 1'b1;
    end else if (rd_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pd_wake_ctrl.sv
module pd_wake_ctrl
  import pd_wake_pkg::*;
#(
  parameter int N_IRQ    = 4,
  parameter int DW       = 8,
  parameter int RUN_THR  = 5,
  parameter int STOP_THR = 3000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_req_i,
  input  logic             clk_stop_i,
  input  logic             wake_i,
  input  logic             ctx_keep_i,
  input  logic             core_rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_ack_i,
  input  logic [1:0]       ab_req_i,
  input  logic             sclk_ext_i,
  input  logic             rx_valid_i,
  input  logic [DW-1:0]    rx_data_i,
  input  logic             rx_rd_i,
  output logic             halt_o,
  output logic             clk_en_o,
  output logic             core_rst_o,
  output logic [N_IRQ-1:0] irq_pend_o,
  output logic [1:0]       ab_go_o,
  output logic [DW-1:0]    rx_data_o,
  output logic             rx_full_o
);
  localparam int MAX_THR = (STOP_THR > RUN_THR) ? STOP_THR : RUN_THR;
  localparam int CW      = $clog2(MAX_THR + 1);

  pd_state_e     state_q;
  logic          stopped_q, rst_exit_q;
  logic          hit, ab_left, sport_live, ctx_clr;
  logic [CW-1:0] thr;

  assign thr        = stopped_q ? CW'(STOP_THR) : CW'(RUN_THR);
  assign sport_live = !(state_q == S_PDOWN && stopped_q && !sclk_ext_i);
  assign ctx_clr    = (state_q == S_WAKE) && rst_exit_q;

  pd_rst_timer #(.CW(CW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == S_PDOWN),
    .low_i  (!core_rst_ni),
    .thr_i  (thr),
    .hit_o  (hit)
  );

  pd_event_latch #(.N_IRQ(N_IRQ), .N_AB(2)) i_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (ctx_clr),
    .irq_i      (irq_i),
    .irq_ack_i  (irq_ack_i),
    .ab_req_i   (ab_req_i),
    .ab_cap_i   ((state_q != S_RUN) && sport_live),
    .ab_pass_i  (state_q == S_RUN),
    .drain_i    (state_q == S_RESUME),
    .irq_pend_o (irq_pend_o),
    .ab_go_o    (ab_go_o),
    .ab_left_o  (ab_left)
  );

  pd_rx_hold #(.DW(DW)) i_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rx_valid_i && sport_live),
    .data_i (rx_data_i),
    .rd_i   (rx_rd_i),
    .data_o (rx_data_o),
    .full_o (rx_full_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_RUN;
      stopped_q  <= 1'b0;
      rst_exit_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_RUN: if (pd_req_i) begin
          state_q   <= S_PDOWN;
          stopped_q <= clk_stop_i;
        end
        S_PDOWN: if (hit) begin
          state_q    <= S_WAKE;
          rst_exit_q <= 1'b1;
        end else if (wake_i) begin
          state_q    <= S_WAKE;
          rst_exit_q <= !ctx_keep_i;
        end
        S_WAKE:   state_q <= S_RESUME;
        S_RESUME: if (!ab_left) state_q <= S_RUN;
        default:  state_q <= S_RUN;
      endcase
    end
  end

  assign halt_o     = (state_q != S_RUN);
  assign clk_en_o   = !(state_q == S_PDOWN && stopped_q);
  assign core_rst_o = ctx_clr || (state_q == S_RUN && !core_rst_ni);
endmodule

// File: rtl/pd_wake_ctrl_chk.sv
module pd_wake_ctrl_chk #(
  parameter int N_IRQ = 4,
  parameter int DW    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             halt_o,
  input logic             clk_en_o,
  input logic             core_rst_o,
  input logic [N_IRQ-1:0] irq_pend_o,
  input logic [N_IRQ-1:0] irq_ack_i,
  input logic [1:0]       ab_go_o,
  input logic             rx_valid_i,
  input logic [DW-1:0]    rx_data_o
);
  // R2: the core clock is never gated while the core runs
  a_r2_gate_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> halt_o);

  // R9: deferred replay issues at most one transfer per cycle
  a_r9_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> $onehot0(ab_go_o));

  // R9: nothing is issued while the core clock is stopped
  a_r9_quiet_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> (ab_go_o == 2'b00));

  // R8: the exit reset lasts a single cycle
  a_r8_rst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_o && halt_o) |=> !core_rst_o);

  // R7: a pending bit falls only by acknowledge or context reset
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_rst_o |=> (($past(irq_pend_o) & ~irq_pend_o & ~$past(irq_ack_i)) == '0));

  // R10: receive register holds without a receive strobe
  a_r10_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(rx_data_o));
endmodule

bind pd_wake_ctrl pd_wake_ctrl_chk #(.N_IRQ(N_IRQ), .DW(DW)) i_chk (.*);

// File: tb/test_pd_wake_ctrl.sv
module test_pd_wake_ctrl;
  localparam int NI = 4;
  localparam int DW = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pd_req_i = 0, clk_stop_i = 0, wake_i = 0, ctx_keep_i = 1, core_rst_ni = 1;
  logic [NI-1:0] irq_i = '0, irq_ack_i = '0;
  logic [1:0] ab_req_i = '0;
  logic sclk_ext_i = 1, rx_valid_i = 0, rx_rd_i = 0;
  logic [DW-1:0] rx_data_i = '0;
  logic halt_o, clk_en_o, core_rst_o, rx_full_o;
  logic [NI-1:0] irq_pend_o;
  logic [1:0] ab_go_o;
  logic [DW-1:0] rx_data_o;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pd_wake_ctrl i_pd_wake_ctrl (.clk_i(clk), .*);

  typedef struct packed {
    logic        stop;
    logic [11:0] len;
    logic        exits;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 12'd4,    1'b0},  // R3
    '{1'b0, 12'd5,    1'b1},  // R3
    '{1'b0, 12'd1,    1'b0},  // R5
    '{1'b1, 12'd5,    1'b0},  // R4
    '{1'b1, 12'd2999, 1'b0},  // R4
    '{1'b1, 12'd3000, 1'b1},  // R4
    '{1'b0, 12'd9,    1'b1}   // R3
  };

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic enter_pd(logic stop);
    pd_req_i = 1; clk_stop_i = stop;
    tick();
    pd_req_i = 0; clk_stop_i = 0;
  endtask

  task automatic keep_exit();
    wake_i = 1; ctx_keep_i = 1;
    tick();
    wake_i = 0;
    tick(2);
  endtask

  task automatic low_pulse(int n);
    core_rst_ni = 0;
    tick(n);
    core_rst_ni = 1;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #12 rst_ni = 1;
    tick();
    chk("R1 halt", halt_o, 0);
    chk("R1 clk_en", clk_en_o, 1);
    chk("R1 core_rst", core_rst_o, 0);
    chk("R1 pend", irq_pend_o, 0);
    chk("R1 ab_go", ab_go_o, 0);
    chk("R1 rx_full", rx_full_o, 0);

    // reset-pulse table, R3 R4 R5
    foreach (VECS[k]) begin
      enter_pd(VECS[k].stop);
      chk("R2 halt", halt_o, 1);
      chk("R2 clk_en", clk_en_o, !VECS[k].stop);
      low_pulse(VECS[k].len);
      tick(2);
      chk(VECS[k].stop ? "R4 exit" : "R3 exit", !halt_o, VECS[k].exits);
      if (!VECS[k].exits) keep_exit();
    end

    // R5: split pulse does not accumulate
    enter_pd(0);
    low_pulse(3); tick(); low_pulse(3); tick();
    chk("R5 split", halt_o, 1);
    low_pulse(5);
    chk("R8 wake rst", core_rst_o, 1);
    tick();
    chk("R8 rst one cycle", core_rst_o, 0);
    tick();
    chk("R5 exits", halt_o, 0);

    // R7 R8: latch and keep
    enter_pd(1);
    irq_i = 4'b0101; tick(); irq_i = '0;
    chk("R7 latched", irq_pend_o, 4'b0101);
    keep_exit();
    chk("R8 kept", irq_pend_o, 4'b0101);
    irq_ack_i = 4'b0001; tick(); irq_ack_i = '0;
    chk("R7 ack", irq_pend_o, 4'b0100);

    // R8: wake without context keep clears
    enter_pd(0);
    irq_i = 4'b1000; tick(); irq_i = '0;
    wake_i = 1; ctx_keep_i = 0; tick(); wake_i = 0; ctx_keep_i = 1;
    chk("R8 ctx rst", core_rst_o, 1);
    tick();
    chk("R8 cleared", irq_pend_o, 0);
    tick();

    // R9 R6: deferred replay order
    enter_pd(0);
    ab_req_i = 2'b11; tick(); ab_req_i = '0;
    chk("R9 none asleep", ab_go_o, 0);
    wake_i = 1; tick(); wake_i = 0;
    chk("R6 wake clk_en", clk_en_o, 1);
    chk("R6 wake halt", halt_o, 1);
    chk("R9 wake quiet", ab_go_o, 0);
    tick();
    chk("R9 rx first", ab_go_o, 2'b01);
    tick();
    chk("R9 tx second", ab_go_o, 2'b10);
    chk("R6 still halted", halt_o, 1);
    tick();
    chk("R6 run", halt_o, 0);
    chk("R9 done", ab_go_o, 0);

    // R9: reset exit discards
    enter_pd(0);
    ab_req_i = 2'b10; tick(); ab_req_i = '0;
    low_pulse(5);
    tick();
    chk("R9 discarded", ab_go_o, 0);
    tick();
    chk("R9 run after discard", halt_o, 0);

    // R11: stopped clock, internal serial clock
    enter_pd(1);
    sclk_ext_i = 0;
    rx_valid_i = 1; rx_data_i = 8'hA5; ab_req_i = 2'b01; tick();
    rx_valid_i = 0; ab_req_i = '0;
    chk("R11 rx ignored", rx_full_o, 0);
    wake_i = 1; tick(); wake_i = 0; tick();
    chk("R11 ab ignored", ab_go_o, 0);
    tick();
    sclk_ext_i = 1;

    // R10: external serial clock, held across reset exit
    enter_pd(1);
    rx_valid_i = 1; rx_data_i = 8'h3C; tick(); rx_valid_i = 0;
    chk("R10 full", rx_full_o, 1);
    low_pulse(3000);
    tick(2);
    chk("R10 data kept", rx_data_o, 8'h3C);
    chk("R10 full kept", rx_full_o, 1);
    rx_rd_i = 1; tick(); rx_rd_i = 0;
    chk("R10 read", rx_full_o, 0);

    // R12: pass-through while running
    ab_req_i = 2'b10; #1;
    chk("R12 ab pass", ab_go_o, 2'b10);
    ab_req_i = '0;
    core_rst_ni = 0; #1;
    chk("R12 rst pass", core_rst_o, 1);
    core_rst_ni = 1;
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule